// File: doc/BRIEF.md
# Match-Capture Timer

A 32-bit timer/counter peripheral behind a simple word-addressed register bus. The count register advances either once every (prescale + 1) enabled clock cycles, or on chosen edges of one of several external count inputs. Four match channels compare the count against programmable values. On a match, a channel can raise an interrupt flag and always requests a DMA transfer. It also drives its match output pin high, low or to the opposite level, as its two-bit action field selects. Two capture channels copy the running count into read-only capture registers on chosen edges of their input pins, and can raise interrupt flags.

Software clears interrupt flags by writing ones to them. Clearing a match flag bit also withdraws that channel's DMA request. External count and capture pins are asynchronous; each passes through a two-flop synchronizer before edge detection. The single interrupt line is the OR of all flags.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads zero, and match_out, dma_req and irq are low.
- R2: The flag register (offset 0x00) holds match flags 0-3 in bits 0-3 and capture flags 0-1 in bits 4-5; bits 31:6 always read zero.
- R3: Writing a one to a flag bit clears it; writing a zero leaves the flag unchanged.
- R4: Writing a one to match flag bit i at 0x00 withdraws dma_req[i], whether or not flag i was set.
- R5: When a flag-clearing write and a new event for the same flag or DMA request fall in the same cycle, the flag or request stays set.
- R6: A capture event loads the current count into capture register 0 (0x2C) or 1 (0x30); these reset to zero and ignore bus writes.
- R7: Capture control (0x28) gives channel c bits 4c (enable), 4c+1 (rising edge), 4c+2 (falling edge), 4c+3 (set flag); a capture needs enable and a selected edge, and sets its flag only if bit 4c+3 is set.
- R8: In timer mode the count (0x08) increments once every prescale (0x0C) + 1 enabled cycles; the prescale counter (0x10) then returns to zero.
- R9: Count control (0x70) bits 1:0 select 00 timer, 01 rising edges, 10 falling edges, 11 both edges of the selected count input.
- R10: Timer control (0x04) bit 0 enables counting; while bit 1 is set, the count and the prescale counter are held at zero.
- R11: A match occurs when the count steps to the value of match register i (0x18 + 4i); it sets flag i only if bit i of 0x14 is set, always sets dma_req[i], and applies action field bits 4+2i..5+2i of the external-match register (0x3C): 00 none, 01 clear, 10 set, 11 toggle to pin state bit i.
- R12: Count control bits 3:2 choose which count input is counted; edges on the other inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cnt_in | input | N_CNT_IN | Asynchronous external count inputs |
| cap_in | input | N_CAP | Asynchronous capture inputs |
| match_out | output | N_MATCH | External match pin states |
| dma_req | output | N_MATCH | Per-match DMA requests |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The bench builds the block with its defaults: 32-bit count, four match channels, two capture channels and four count inputs. With four match channels, all four action codes can act at once in one run, and the capture flags fall at bits 4 and 5. The count-input select field covers exactly the four inputs, so an input other than the selected one can be shown to be ignored. Capture and clear timing is predictable through the two synchronizer flops, so the same-cycle clear-and-set race is driven exactly.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
// Shared encodings and register offsets for the match-capture timer.
package mct_pkg;

    typedef enum logic [1:0] {
        CM_TIMER = 2'b00,
        CM_RISE  = 2'b01,
        CM_FALL  = 2'b10,
        CM_BOTH  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        MA_NONE   = 2'b00,
        MA_CLEAR  = 2'b01,
        MA_SET    = 2'b10,
        MA_TOGGLE = 2'b11
    } match_act_e;

    localparam logic [7:0] OFS_FLAGS  = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_COUNT  = 8'h08;
    localparam logic [7:0] OFS_PRESC  = 8'h0C;
    localparam logic [7:0] OFS_PCNT   = 8'h10;
    localparam logic [7:0] OFS_MEN    = 8'h14;
    localparam logic [7:0] OFS_MVAL0  = 8'h18;
    localparam logic [7:0] OFS_CAPCTL = 8'h28;
    localparam logic [7:0] OFS_CAPV0  = 8'h2C;
    localparam logic [7:0] OFS_EXTM   = 8'h3C;
    localparam logic [7:0] OFS_CMODE  = 8'h70;

endpackage

// File: rtl/mct_sync_edge.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus edge detector, one lane per input bit.
// Assumes inputs are asynchronous; an edge is reported for one cycle,
// two clocks after the pin changes.
module mct_sync_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [2:0] sh_q;

        // Shift the pin through two sync stages and one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[1:0], pin_i[g]};
        end

        assign rise_o[g] =  sh_q[1] & ~sh_q[2];
        assign fall_o[g] = ~sh_q[1] &  sh_q[2];
    end
endmodule

// File: rtl/mct_counter.sv
`timescale 1ns/1ps
// Count register and prescale counter. Timer mode steps the count when
// the prescale counter reaches the prescale value; edge modes step it on
// the selected synchronized edge. Hold forces both to zero; a bus load
// takes priority over a step and suppresses the step indication.
module mct_counter
    import mct_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             hold_i,
    input  cnt_mode_e        mode_i,
    input  logic             ext_rise_i,
    input  logic             ext_fall_i,
    input  logic [CNT_W-1:0] presc_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic [CNT_W-1:0] tc_o,
    output logic [CNT_W-1:0] pc_o,
    output logic             inc_o,
    output logic [CNT_W-1:0] tc_inc_o
);
    logic [CNT_W-1:0] tc_q, pc_q;
    logic             ext_ev, presc_done, step;

    // Decide whether the count advances this cycle.
    always_comb begin
        unique case (mode_i)
            CM_RISE: ext_ev = ext_rise_i;
            CM_FALL: ext_ev = ext_fall_i;
            CM_BOTH: ext_ev = ext_rise_i | ext_fall_i;
            default: ext_ev = 1'b0;
        endcase
        presc_done = (pc_q >= presc_i);
        step = run_i & ~hold_i & ((mode_i == CM_TIMER) ? presc_done : ext_ev);
    end

    assign tc_inc_o = tc_q + 1'b1;
    assign inc_o    = step & ~ld_i;
    assign tc_o     = tc_q;
    assign pc_o     = pc_q;

    // Prescale counter: wraps at the prescale value, timer mode only.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i)                  pc_q <= '0;
        else if (mode_i != CM_TIMER)           pc_q <= '0;
        else if (run_i)                        pc_q <= presc_done ? '0 : pc_q + 1'b1;
    end

    // Count register: hold, then bus load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) tc_q <= '0;
        else if (ld_i)        tc_q <= ld_val_i;
        else if (step)        tc_q <= tc_inc_o;
    end
endmodule

// File: rtl/mct_match.sv
`timescale 1ns/1ps
// Match comparators and the external-match register. A channel hits when
// the count steps onto its match value. The register holds pin states in
// bits N-1:0 and a 2-bit action per channel above them; a bus write is
// applied first and hit actions on top of it in the same cycle.
module mct_match
    import mct_pkg::*;
#(
    parameter int unsigned N_MATCH = 4,
    parameter int unsigned CNT_W   = 32,
    localparam int unsigned EXT_W  = 3 * N_MATCH
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            inc_i,
    input  logic [CNT_W-1:0]                tc_inc_i,
    input  logic [N_MATCH-1:0][CNT_W-1:0]   mval_i,
    input  logic                            ext_wr_i,
    input  logic [EXT_W-1:0]                ext_wdata_i,
    output logic [N_MATCH-1:0]              hit_o,
    output logic [EXT_W-1:0]                ext_q_o
);
    logic [EXT_W-1:0] ext_q, ext_d;

    for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
        assign hit_o[g] = inc_i & (tc_inc_i == mval_i[g]);
    end

    // Merge the bus write with the actions of channels that hit.
    always_comb begin
        ext_d = ext_wr_i ? ext_wdata_i : ext_q;
        for (int i = 0; i < N_MATCH; i++) begin
            if (hit_o[i]) begin
                unique case (match_act_e'(ext_d[N_MATCH + 2*i +: 2]))
                    MA_CLEAR:  ext_d[i] = 1'b0;
                    MA_SET:    ext_d[i] = 1'b1;
                    MA_TOGGLE: ext_d[i] = ~ext_d[i];
                    default:   ext_d[i] = ext_d[i];
                endcase
            end
        end
    end

    // External-match register.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= ext_d;
    end

    assign ext_q_o = ext_q;
endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
// Match-capture timer top: register file, flags, DMA requests and capture
// registers around the counter, match and synchronizer blocks.
// Assumes CNT_W <= 32, N_MATCH <= 4, N_CAP <= 4 and N_CNT_IN <= 4 so the
// fixed register layout holds; accesses with bus_addr[1:0] != 0 are ignored.
module mct_timer
    import mct_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned N_MATCH  = 4,
    parameter int unsigned N_CAP    = 2,
    parameter int unsigned N_CNT_IN = 4,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [N_CNT_IN-1:0] cnt_in,
    input  logic [N_CAP-1:0]    cap_in,
    output logic [N_MATCH-1:0]  match_out,
    output logic [N_MATCH-1:0]  dma_req,
    output logic                irq
);
    localparam int unsigned FLAG_W = N_MATCH + N_CAP;
    localparam int unsigned EXT_W  = 3 * N_MATCH;
    localparam int unsigned CCR_W  = 4 * N_CAP;

    logic [1:0]                      tcr_q;
    logic [CNT_W-1:0]                presc_q;
    logic [N_MATCH-1:0]              men_q;
    logic [N_MATCH-1:0][CNT_W-1:0]   mval_q;
    logic [CCR_W-1:0]                capctl_q;
    logic [N_CAP-1:0][CNT_W-1:0]     capv_q;
    logic [3:0]                      cmode_q;
    logic [FLAG_W-1:0]               flag_q;
    logic [N_MATCH-1:0]              dma_q;

    logic [N_CNT_IN-1:0] cin_rise, cin_fall;
    logic [N_CAP-1:0]    cap_rise, cap_fall, cap_ev, cap_set;
    logic                sel_rise, sel_fall;
    logic [CNT_W-1:0]    tc_w, pc_w, tc_inc_w;
    logic                inc_w;
    logic [N_MATCH-1:0]  match_hit;
    logic [EXT_W-1:0]    ext_w;
    logic                word_ok, wr_en;
    logic [FLAG_W-1:0]   flag_clr;

    function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign word_ok = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel & bus_wr & word_ok;

    mct_sync_edge #(.WIDTH(N_CNT_IN)) u_cin_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(cnt_in), .rise_o(cin_rise), .fall_o(cin_fall)
    );

    mct_sync_edge #(.WIDTH(N_CAP)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(cap_in), .rise_o(cap_rise), .fall_o(cap_fall)
    );

    // Pick the edges of the count input chosen by count-control bits 3:2.
    always_comb begin
        sel_rise = 1'b0;
        sel_fall = 1'b0;
        for (int k = 0; k < N_CNT_IN; k++) begin
            if (cmode_q[3:2] == 2'(k)) begin
                sel_rise = cin_rise[k];
                sel_fall = cin_fall[k];
            end
        end
    end

    mct_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n),
        .run_i(tcr_q[0]), .hold_i(tcr_q[1]),
        .mode_i(cnt_mode_e'(cmode_q[1:0])),
        .ext_rise_i(sel_rise), .ext_fall_i(sel_fall),
        .presc_i(presc_q),
        .ld_i(wr_en && at(bus_addr, OFS_COUNT)),
        .ld_val_i(bus_wdata[CNT_W-1:0]),
        .tc_o(tc_w), .pc_o(pc_w), .inc_o(inc_w), .tc_inc_o(tc_inc_w)
    );

    mct_match #(.N_MATCH(N_MATCH), .CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .inc_i(inc_w), .tc_inc_i(tc_inc_w), .mval_i(mval_q),
        .ext_wr_i(wr_en && at(bus_addr, OFS_EXTM)),
        .ext_wdata_i(bus_wdata[EXT_W-1:0]),
        .hit_o(match_hit), .ext_q_o(ext_w)
    );

    // Control registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcr_q    <= '0;
            presc_q  <= '0;
            men_q    <= '0;
            capctl_q <= '0;
            cmode_q  <= '0;
        end else if (wr_en) begin
            if (at(bus_addr, OFS_CTRL))   tcr_q    <= bus_wdata[1:0];
            if (at(bus_addr, OFS_PRESC))  presc_q  <= bus_wdata[CNT_W-1:0];
            if (at(bus_addr, OFS_MEN))    men_q    <= bus_wdata[N_MATCH-1:0];
            if (at(bus_addr, OFS_CAPCTL)) capctl_q <= bus_wdata[CCR_W-1:0];
            if (at(bus_addr, OFS_CMODE))  cmode_q  <= bus_wdata[3:0];
        end
    end

    for (genvar g = 0; g < N_MATCH; g++) begin : g_mval
        // Match value register for channel g.
        always_ff @(posedge clk) begin
            if (!rst_n) mval_q[g] <= '0;
            else if (wr_en && at(bus_addr, OFS_MVAL0 + 8'(4*g))) mval_q[g] <= bus_wdata[CNT_W-1:0];
        end
    end

    for (genvar c = 0; c < N_CAP; c++) begin : g_cap
        assign cap_ev[c]  = capctl_q[4*c] &
                            ((capctl_q[4*c+1] & cap_rise[c]) | (capctl_q[4*c+2] & cap_fall[c]));
        assign cap_set[c] = cap_ev[c] & capctl_q[4*c+3];

        // Capture register c: loads the count on an event, read-only.
        always_ff @(posedge clk) begin
            if (!rst_n)      capv_q[c] <= '0;
            else if (cap_ev[c]) capv_q[c] <= tc_w;
        end
    end

    assign flag_clr = (wr_en && at(bus_addr, OFS_FLAGS)) ? bus_wdata[FLAG_W-1:0] : '0;

    // Interrupt flags and DMA requests: new events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            dma_q  <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | {cap_set, match_hit & men_q};
            dma_q  <= (dma_q & ~flag_clr[N_MATCH-1:0]) | match_hit;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (word_ok) begin
            if (at(bus_addr, OFS_FLAGS))  bus_rdata = 32'(flag_q);
            if (at(bus_addr, OFS_CTRL))   bus_rdata = 32'(tcr_q);
            if (at(bus_addr, OFS_COUNT))  bus_rdata = 32'(tc_w);
            if (at(bus_addr, OFS_PRESC))  bus_rdata = 32'(presc_q);
            if (at(bus_addr, OFS_PCNT))   bus_rdata = 32'(pc_w);
            if (at(bus_addr, OFS_MEN))    bus_rdata = 32'(men_q);
            if (at(bus_addr, OFS_CAPCTL)) bus_rdata = 32'(capctl_q);
            if (at(bus_addr, OFS_EXTM))   bus_rdata = 32'(ext_w);
            if (at(bus_addr, OFS_CMODE))  bus_rdata = 32'(cmode_q);
            for (int i = 0; i < N_MATCH; i++)
                if (at(bus_addr, OFS_MVAL0 + 8'(4*i))) bus_rdata = 32'(mval_q[i]);
            for (int i = 0; i < N_CAP; i++)
                if (at(bus_addr, OFS_CAPV0 + 8'(4*i))) bus_rdata = 32'(capv_q[i]);
        end
    end

    assign match_out = ext_w[N_MATCH-1:0];
    assign dma_req   = dma_q;
    assign irq       = |flag_q;
endmodule

// File: rtl/mct_timer_chk.sv
`timescale 1ns/1ps
// Assertion checker for mct_timer, attached by bind. Observes the bus,
// the DMA requests and internal flag, capture and counter state.
module mct_timer_chk #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_MATCH = 4,
    parameter int unsigned N_CAP   = 2,
    parameter int unsigned ADDR_W  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic [31:0]                   bus_rdata,
    input logic [N_MATCH-1:0]            dma_req,
    input logic [N_MATCH-1:0]            match_hit,
    input logic [N_CAP-1:0]              cap_ev,
    input logic [N_CAP-1:0][CNT_W-1:0]   capv_q,
    input logic [1:0]                    tcr_q,
    input logic [CNT_W-1:0]              tc_w,
    input logic [CNT_W-1:0]              pc_w
);
    localparam int unsigned FLAG_W = N_MATCH + N_CAP;

    logic flag_wr;
    assign flag_wr = bus_sel && bus_wr && (bus_addr == '0);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[31:FLAG_W] == '0)); // R2

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tcr_q[1] |=> (tc_w == '0 && pc_w == '0)); // R10

    for (genvar i = 0; i < N_MATCH; i++) begin : g_m
        AST_HIT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            match_hit[i] |=> dma_req[i]); // R5

        AST_DMA_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_wr && bus_wdata[i] && !match_hit[i]) |=> !dma_req[i]); // R4
    end

    for (genvar c = 0; c < N_CAP; c++) begin : g_c
        AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_ev[c] |=> $stable(capv_q[c])); // R6
    end
endmodule

bind mct_timer mct_timer_chk #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .match_hit(match_hit),
    .cap_ev(cap_ev), .capv_q(capv_q),
    .tcr_q(tcr_q), .tc_w(tc_w), .pc_w(pc_w)
);

// File: tb/mct_timer_tb_top.sv
`timescale 1ns/1ps
// Directed bench for mct_timer: one task per scenario.
module mct_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  cnt_in = '0;
    logic [1:0]  cap_in = '0;
    logic [3:0]  match_out, dma_req;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    mct_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_in(cnt_in), .cap_in(cap_in), .match_out(match_out),
        .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk_reg("R1 flags", 8'h00, 0);
        chk_reg("R1 ctrl", 8'h04, 0);
        chk_reg("R1 count", 8'h08, 0);
        chk_reg("R1 cap0", 8'h2C, 0);
        chk_reg("R1 cap1", 8'h30, 0);
        chk_reg("R1 extm", 8'h3C, 0);
        chk_reg("R1 cmode", 8'h70, 0);
        check("R1 pins", {27'd0, irq, match_out}, 0);
        check("R1 dma", 32'(dma_req), 0);
    endtask

    task automatic t_capture();
        wr(8'h04, 32'h2); wr(8'h04, 32'h0);
        wr(8'h08, 32'h1234);
        wr(8'h28, 32'h0B);                          // ch0: enable, rise, flag
        @(negedge clk) cap_in[0] = 1'b1; idle(5);
        chk_reg("R6 capture value", 8'h2C, 32'h1234);
        chk_reg("R7 capture flag", 8'h00, 32'h10);
        check("R7 irq", 32'(irq), 1);
        wr(8'h2C, 32'hDEAD);
        chk_reg("R6 read-only", 8'h2C, 32'h1234);
        wr(8'h08, 32'h55);
        @(negedge clk) cap_in[0] = 1'b0; idle(5);
        chk_reg("R7 unselected edge", 8'h2C, 32'h1234);
        wr(8'h28, 32'h6B);                          // ch1 without enable
        @(negedge clk) cap_in[1] = 1'b1; idle(5);
        @(negedge clk) cap_in[1] = 1'b0; idle(5);
        chk_reg("R7 disabled channel", 8'h30, 0);
        wr(8'h28, 32'h5B);                          // ch1: enable, fall, no flag
        @(negedge clk) cap_in[1] = 1'b1; idle(5);
        @(negedge clk) cap_in[1] = 1'b0; idle(5);
        chk_reg("R7 falling capture", 8'h30, 32'h55);
        chk_reg("R7 no flag", 8'h00, 32'h10);
    endtask

    task automatic t_w1c();
        wr(8'h00, 32'h0);
        chk_reg("R3 write zero", 8'h00, 32'h10);
        wr(8'h00, 32'hFFFF_FFC0);
        chk_reg("R2 reserved", 8'h00, 32'h10);
        wr(8'h00, 32'h10);
        chk_reg("R3 clear", 8'h00, 0);
    endtask

    task automatic t_set_wins();
        // cap_in[0] is low; channel 0 captures on rising edges.
        @(negedge clk) cap_in[0] = 1'b1;
        idle(5);
        chk_reg("R5 pre-set", 8'h00, 32'h10);
        @(negedge clk) cap_in[0] = 1'b0; idle(5);
        @(negedge clk) cap_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h10;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
        chk_reg("R5 set beats clear", 8'h00, 32'h10);
        wr(8'h00, 32'h10);
        @(negedge clk) cap_in[0] = 1'b0; idle(5);
    endtask

    task automatic t_timer();
        wr(8'h04, 32'h2);
        wr(8'h0C, 32'd3);
        wr(8'h04, 32'h1);
        repeat (39) @(posedge clk);
        wr(8'h04, 32'h0);
        chk_reg("R8 prescaled count", 8'h08, 32'd10);
        chk_reg("R8 prescale wrap", 8'h10, 0);
        wr(8'h04, 32'h3); idle(5);
        chk_reg("R10 hold count", 8'h08, 0);
        chk_reg("R10 hold prescale", 8'h10, 0);
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'd0);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) cnt_in[idx] = 1'b1; idle(3);
            @(negedge clk) cnt_in[idx] = 1'b0; idle(3);
        end
    endtask

    task automatic t_counter();
        wr(8'h04, 32'h2); wr(8'h70, 32'h9); wr(8'h04, 32'h1);
        pulse(2, 3);
        pulse(0, 3);
        idle(4); wr(8'h04, 32'h0);
        chk_reg("R9 R12 rising on input 2", 8'h08, 32'd3);
        wr(8'h04, 32'h2); wr(8'h70, 32'hB); wr(8'h04, 32'h1);
        pulse(2, 3); idle(4); wr(8'h04, 32'h0);
        chk_reg("R9 both edges", 8'h08, 32'd6);
        wr(8'h04, 32'h2); wr(8'h70, 32'h6); wr(8'h04, 32'h1);   // input 1, falling
        pulse(1, 2); pulse(2, 2); idle(4); wr(8'h04, 32'h0);
        chk_reg("R9 R12 falling on input 1", 8'h08, 32'd2);
        wr(8'h70, 32'h0);
    endtask

    task automatic t_match();
        wr(8'h04, 32'h2);
        wr(8'h14, 32'h1);
        wr(8'h18, 32'd5);
        wr(8'h1C, 32'd3);
        wr(8'h20, 32'hFFFF);
        wr(8'h24, 32'hFFFF);
        wr(8'h3C, 32'h1B4);     // pin2=1; ch0 toggle, ch1 set, ch2 clear
        wr(8'h04, 32'h1);
        idle(10);
        wr(8'h04, 32'h0);
        check("R11 pins", 32'(match_out), 32'h7);
        chk_reg("R11 flag only if enabled", 8'h00, 32'h1);
        check("R11 dma", 32'(dma_req), 32'h3);
        chk_reg("R11 extm readback", 8'h3C, 32'h1B7);
        wr(8'h00, 32'h1);
        chk_reg("R4 flag cleared", 8'h00, 0);
        check("R4 dma withdrawn", 32'(dma_req), 32'h2);
        wr(8'h00, 32'h2);
        check("R4 dma withdrawn without flag", 32'(dma_req), 0);
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_capture();
        t_w1c();
        t_set_wins();
        t_timer();
        t_counter();
        t_match();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule